// File: doc/BRIEF.md
# Break trigger pulse controller

This block sits behind two break-condition comparators. Each comparator sends a single-cycle match pulse when its condition hits. The block merges those pulses into one active-high, registered trigger output. The trigger stays high for a programmable number of bus clock cycles: one, two, four or eight. Each channel has its own suppression bit, which stops that channel from starting a trigger.

Each channel also has a sticky match flag. A match sets the flag whether or not that channel's trigger is suppressed. The flag stays set until software writes 0 to its bit.

All fields live in one 32-bit control word. Writing it takes a one-cycle write strobe with data. The word can be read combinationally at any time.

Top module: `brk_trig_ctrl`

## Requirements
- R1: After reset, `trig_o` is 0 and `rd_data_o` reads 0.
- R2: An enabled match in a cycle sets `trig_o` to 1 from the following cycle on.
- R3: The select field at bits 17:16 sets the trigger length: 00 gives 1 cycle, 01 gives 2, 10 gives 4 and 11 gives 8.
- R4: Bit 18 suppresses the trigger for channel 0 and bit 19 does so for channel 1. A match on a suppressed channel starts no trigger.
- R5: Enabled matches on both channels in the same cycle produce one pulse of the selected length.
- R6: An enabled match that arrives while the trigger is high restarts the length count. The trigger then falls one full length after the latest match.
- R7: The length is taken from the select value in the cycle of the match. Rewriting the select during a pulse does not change that pulse.
- R8: The channel 0 flag is at bit 15 and the channel 1 flag is at bit 14. A flag becomes 1 in the cycle after a match on its channel, even when that channel is suppressed.
- R9: A flag clears only on a write with 0 in its bit. Writing 1 leaves it unchanged. A match in the same cycle as a clearing write leaves the flag at 1.
- R10: Bits 31:20 and 13:0 read as 0, and writes to them have no effect.
- R11: The suppression and select fields read back the last value written to them, from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Data written to the control word |
| rd_data_o | output | 32 | Current value of the control word |
| match_i | input | 2 | Single-cycle match pulses; bit 0 is channel 0 and bit 1 is channel 1 |
| trig_o | output | 1 | Registered trigger pulse, active high |

## Verification
The first patterns are directed. A single isolated match is sent at each select value, and the high cycles are counted; this separates the four length encodings. Matches on a suppressed channel and on an enabled channel show whether the gating works per channel. A simultaneous pair of matches is then compared against a match repeated partway through a pulse: the first must give exactly one length and the second must extend the pulse. A select rewrite during a pulse, and a clearing write that lands on a match, test the sampling point and the priority of set over clear. Long random runs of sparse matches mixed with writes then compare every cycle against a bench model.

// File: rtl/brk_trig_pkg.sv
package brk_trig_pkg;
  localparam int NUM_CH   = 2;
  localparam int SEL_W    = 2;
  localparam int REG_W    = 32;
  localparam int DIS_LSB  = 18;  // bit DIS_LSB + c suppresses channel c
  localparam int SEL_LSB  = 16;
  localparam int FLAG_MSB = 15;  // flag of channel c sits at FLAG_MSB - c
  localparam int CNT_W    = (1 << SEL_W) - 1;
endpackage

// File: rtl/brk_ctrl_reg.sv
module brk_ctrl_reg
  import brk_trig_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [NUM_CH-1:0] match_i,
  output logic [NUM_CH-1:0] dis_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [NUM_CH-1:0] flag_o
);
  logic [NUM_CH-1:0] dis_q;
  logic [SEL_W-1:0]  sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_q <= '0;
      sel_q <= '0;
    end else if (wr_en_i) begin
      dis_q <= wr_data_i[DIS_LSB +: NUM_CH];
      sel_q <= wr_data_i[SEL_LSB +: SEL_W];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_flag
    logic flag_q;
    logic clr;
    assign clr = wr_en_i && !wr_data_i[FLAG_MSB-c];

    // set has priority over clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         flag_q <= 1'b0;
      else if (match_i[c]) flag_q <= 1'b1;
      else if (clr)        flag_q <= 1'b0;
    end
    assign flag_o[c] = flag_q;

    assert_flag_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_i[c] |=> flag_o[c]);
    assert_flag_clear_only_by_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flag_o[c]) |-> $past(wr_en_i && !wr_data_i[FLAG_MSB-c] && !match_i[c]));
  end

  assign dis_o = dis_q;
  assign sel_o = sel_q;
endmodule

// File: rtl/brk_pulse_gen.sv
module brk_pulse_gen
  import brk_trig_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             pulse_o
);
  logic             pulse_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   len;

  assign len = (CNT_W+1)'(1) << sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      cnt_q   <= '0;
    end else if (start_i) begin
      pulse_q <= 1'b1;
      cnt_q   <= CNT_W'(len - 1'b1);
    end else if (pulse_q) begin
      if (cnt_q == '0) pulse_q <= 1'b0;
      else             cnt_q   <= cnt_q - 1'b1;
    end
  end

  assign pulse_o = pulse_q;

  assert_start_raises_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> pulse_o);
  assert_idle_stays_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_o && !start_i) |=> !pulse_o);
  assert_count_down_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && !start_i && cnt_q != '0) |=> (pulse_o && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/brk_trig_ctrl.sv
module brk_trig_ctrl
  import brk_trig_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic [NUM_CH-1:0] match_i,
  output logic              trig_o
);
  logic [NUM_CH-1:0] dis;
  logic [SEL_W-1:0]  sel;
  logic [NUM_CH-1:0] flag;
  logic              start;

  brk_ctrl_reg u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .match_i  (match_i),
    .dis_o    (dis),
    .sel_o    (sel),
    .flag_o   (flag)
  );

  assign start = |(match_i & ~dis);

  brk_pulse_gen u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .sel_i  (sel),
    .pulse_o(trig_o)
  );

  always_comb begin
    rd_data_o = '0;
    rd_data_o[DIS_LSB +: NUM_CH] = dis;
    rd_data_o[SEL_LSB +: SEL_W]  = sel;
    for (int c = 0; c < NUM_CH; c++) rd_data_o[FLAG_MSB-c] = flag[c];
  end

  assert_suppressed_no_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_o && (match_i & ~rd_data_o[DIS_LSB +: NUM_CH]) == '0) |=> !trig_o);
  assert_unused_bits_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[REG_W-1:DIS_LSB+NUM_CH] == '0) && (rd_data_o[FLAG_MSB-NUM_CH:0] == '0));
endmodule

// File: tb/sim_brk_trig_ctrl.sv
`timescale 1ns/1ps
module sim_brk_trig_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic [1:0]  match = 0;
  logic        trig;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [1:0] m_dis = 0, m_sel = 0, m_flag = 0;
  int m_rem = 0;
  int hc;

  always #10 clk = ~clk;

  brk_trig_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .match_i(match), .trig_o(trig)
  );

  function automatic logic [31:0] exp_rd();
    logic [31:0] v = 0;
    v[19] = m_dis[1]; v[18] = m_dis[0]; v[17:16] = m_sel;
    v[15] = m_flag[0]; v[14] = m_flag[1];
    return v;
  endfunction

  task automatic model(input bit wr, input logic [31:0] wd, input logic [1:0] m);
    logic [1:0] en = m & ~m_dis;
    if (en != 0) m_rem = 1 << m_sel;
    else if (m_rem > 0) m_rem--;
    for (int c = 0; c < 2; c++)
      m_flag[c] = m[c] | (m_flag[c] & !(wr && !wd[15-c]));
    if (wr) begin m_dis = wd[19:18]; m_sel = wd[17:16]; end
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit wr, input logic [31:0] wd, input logic [1:0] m, input string tag);
    wr_en = wr; wr_data = wd; match = m;
    @(posedge clk);
    model(wr, wd, m);
    @(negedge clk);
    wr_en = 0; match = 0;
    chk(trig === (m_rem != 0), tag, "trig_o", {31'b0, trig}, {31'b0, m_rem != 0});
    chk(rd_data === exp_rd(), tag, "rd_data_o", rd_data, exp_rd());
    if (trig) hc++;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] wd;
    logic [1:0]  m;
    bit          wr;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(trig === 0, "R1", "trig_o", {31'b0, trig}, 0);
    chk(rd_data === 0, "R1", "rd_data_o", rd_data, 0);
    rst_n = 1;
    @(negedge clk);

    // R11 / R10 field readback and unused bits
    step(1, 32'h000F_C000, 0, "R11");
    chk(rd_data === 32'h000F_0000, "R11", "readback", rd_data, 32'h000F_0000);
    step(1, 32'hFFFF_FFFF, 0, "R10");
    chk(rd_data === 32'h000F_0000, "R10", "unused bits", rd_data, 32'h000F_0000);

    // R3 length per select
    for (int s = 0; s < 4; s++) begin
      step(1, 32'h0000_C000 | (s << 16), 0, "R3");
      hc = 0;
      step(0, 0, 2'b01, "R3");
      idle(10, "R3");
      chk(hc == (1 << s), "R3", "pulse length", hc, 1 << s);
    end

    // R4 / R8 suppression, flags still set
    step(1, 32'h0004_0000, 0, "R4");  // ch0 suppressed, flags cleared
    hc = 0;
    step(0, 0, 2'b01, "R4");
    idle(3, "R4");
    chk(hc == 0, "R4", "suppressed ch0 pulses", hc, 0);
    chk(rd_data[15] === 1'b1, "R8", "flag ch0 while suppressed", rd_data[15], 1);
    hc = 0;
    step(0, 0, 2'b10, "R4");
    idle(3, "R4");
    chk(hc == 1, "R4", "enabled ch1 pulses", hc, 1);
    step(1, 32'h0008_C000, 0, "R4");  // ch1 suppressed
    hc = 0;
    step(0, 0, 2'b10, "R4");
    idle(3, "R4");
    chk(hc == 0, "R4", "suppressed ch1 pulses", hc, 0);

    // R5 simultaneous matches
    step(1, 32'h0002_C000, 0, "R5");
    hc = 0;
    step(0, 0, 2'b11, "R5");
    idle(8, "R5");
    chk(hc == 4, "R5", "single pulse length", hc, 4);

    // R6 retrigger
    step(1, 32'h0001_C000, 0, "R6");
    hc = 0;
    step(0, 0, 2'b01, "R6");
    step(0, 0, 2'b01, "R6");
    idle(4, "R6");
    chk(hc == 3, "R6", "extended pulse", hc, 3);

    // R7 select change during pulse
    step(1, 32'h0002_C000, 0, "R7");
    hc = 0;
    step(0, 0, 2'b01, "R7");
    step(1, 32'h0000_C000, 0, "R7");
    idle(6, "R7");
    chk(hc == 4, "R7", "length kept", hc, 4);

    // R9 clear, write-1 no-op, set wins
    step(0, 0, 2'b11, "R9");
    step(1, 32'h0000_4000, 0, "R9");
    chk(rd_data[15:14] === 2'b01, "R9", "clear ch0 keep ch1", rd_data[15:14], 2'b01);
    step(1, 32'h0000_0000, 2'b01, "R9");
    chk(rd_data[15:14] === 2'b10, "R9", "set wins ch0", rd_data[15:14], 2'b10);
    idle(10, "R9");

    // R2 random mix against model
    for (int i = 0; i < 4000; i++) begin
      wr = ($urandom % 8) == 0;
      wd = $urandom;
      if (($urandom % 4) != 0) wd[15:14] = 2'b11;
      m = (($urandom % 3) == 0) ? 2'($urandom) : 2'b00;
      step(wr, wd, m, "R2");
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule